// File: doc/BRIEF.md
# Multi-Route Partitioned Message Queue

This block is a single word-wide buffer memory carved into several independent circular queues, one for each communication route between two bus-side I/O stages. A producer on one side picks a route number and pushes one message word per cycle; a consumer on the other side picks a route number and pops one word per cycle. Each route owns a fixed, contiguous slice of the memory whose extent is set at elaboration, and its write and read pointers wrap inside that slice only.

Each route reports its own registered full and empty flags, and a push onto a full route or a pop from an empty route is dropped and answered with a one-cycle error pulse on that route. Both sides run on one clock; a push and a pop may address the same route in the same cycle.

Top module: `route_part_fifo`

## Requirements
- R1: After synchronous reset every route reports empty=1 and full=0, no error pulse is raised, and rd_valid is 0.
- R2: A word pushed with wr_en on route r is returned by a later pop of route r in push order; rd_data carries it with rd_valid=1 in the cycle after the pop request.
- R3: Traffic on one route never changes another route's stored words, occupancy or flags.
- R4: full[r] is 1 exactly when route r holds as many words as its slice size (defaults: route 0 = 4, route 1 = 8, route 2 = 2, route 3 = 6), empty[r] is 1 exactly when it holds none; both flags reflect the handshakes of the previous cycle.
- R5: A push onto a full route stores nothing and raises wr_err[r] for exactly the following cycle; the route's contents are unchanged.
- R6: A pop from an empty route returns nothing (rd_valid stays 0) and raises rd_err[r] for exactly the following cycle.
- R7: A push and a pop on the same route in one cycle, with the route neither full nor empty, are both taken and the route's occupancy is unchanged.
- R8: Pointers wrap inside their own slice, so FIFO order is kept across many more words than the slice size.
- R9: Acceptance uses the occupancy at the start of the cycle: a simultaneous push and pop on a full route takes the pop and rejects the push; on an empty route it takes the push and rejects the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push request |
| wr_route | input | RW | Route selected for the push |
| wr_data | input | DATA_W | Word to push |
| rd_en | input | 1 | Pop request |
| rd_route | input | RW | Route selected for the pop |
| rd_data | output | DATA_W | Popped word, valid when rd_valid |
| rd_valid | output | 1 | rd_data holds a popped word |
| full | output | NUM_ROUTES | Per-route full flag |
| empty | output | NUM_ROUTES | Per-route empty flag |
| wr_err | output | NUM_ROUTES | Per-route rejected-push pulse |
| rd_err | output | NUM_ROUTES | Per-route rejected-pop pulse |

## Verification
Every cycle the assertions check that no route is both full and empty, that pointers stay inside their own slice, that rejected requests produce their error pulse, that a combined push and pop leaves the flags unchanged, and that simultaneous accepted accesses never hit the same memory word. Only the bench's scenarios can show data order, isolation between routes and correct wrap-around, since those need a model of every stored word; it compares flags, pulses and popped data against a per-route queue model on each clock.

// File: rtl/rtpq_pkg.sv
package rtpq_pkg;
  localparam int unsigned SZ_FIELD_W = 16;

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rtpq_mem.sv
module rtpq_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 20,
  parameter int unsigned AW     = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rtpq_part_ctrl.sv
module rtpq_part_ctrl #(
  parameter int unsigned AW   = 5,
  parameter int unsigned CW   = 4,
  parameter int unsigned BASE = 0,
  parameter int unsigned SIZE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          full,
  output logic          empty,
  output logic          wr_err,
  output logic          rd_err
);
  localparam logic [AW-1:0] LO  = AW'(BASE);
  localparam logic [AW-1:0] HI  = AW'(BASE + SIZE - 1);
  localparam logic [CW-1:0] CAP = CW'(SIZE);

  logic [CW-1:0] count, count_nxt;

  assign wr_go = wr_req && (count != CAP);
  assign rd_go = rd_req && (count != '0);

  always_comb begin
    count_nxt = count;
    if (wr_go && !rd_go) count_nxt = count + 1'b1;
    else if (rd_go && !wr_go) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      wr_ptr <= LO;
      rd_ptr <= LO;
      full   <= 1'b0;
      empty  <= 1'b1;
      wr_err <= 1'b0;
      rd_err <= 1'b0;
    end else begin
      count  <= count_nxt;
      full   <= (count_nxt == CAP);
      empty  <= (count_nxt == '0);
      wr_err <= wr_req && !wr_go;
      rd_err <= rd_req && !rd_go;
      if (wr_go) wr_ptr <= (wr_ptr == HI) ? LO : wr_ptr + 1'b1;
      if (rd_go) rd_ptr <= (rd_ptr == HI) ? LO : rd_ptr + 1'b1;
    end
  end

  // R4
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R8
  ptr_in_slice_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(wr_ptr) >= int'(BASE)) && (int'(wr_ptr) < int'(BASE + SIZE)) &&
    (int'(rd_ptr) >= int'(BASE)) && (int'(rd_ptr) < int'(BASE + SIZE)));

  // R5
  push_full_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full) |=> wr_err);

  // R6
  pop_empty_err_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> rd_err);

  // R7
  both_keep_level_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_go && rd_go) |=> ($stable(full) && $stable(empty)));
endmodule

// File: rtl/route_part_fifo.sv
module route_part_fifo #(
  parameter int unsigned NUM_ROUTES = 4,
  parameter int unsigned DATA_W     = 32,
  parameter logic [NUM_ROUTES*rtpq_pkg::SZ_FIELD_W-1:0] PART_SIZES =
    {16'd6, 16'd2, 16'd8, 16'd4},
  localparam int unsigned RW = rtpq_pkg::width_of(NUM_ROUTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [RW-1:0]         wr_route,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [RW-1:0]         rd_route,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic [NUM_ROUTES-1:0] full,
  output logic [NUM_ROUTES-1:0] empty,
  output logic [NUM_ROUTES-1:0] wr_err,
  output logic [NUM_ROUTES-1:0] rd_err
);
  localparam int unsigned FW = rtpq_pkg::SZ_FIELD_W;

  function automatic int unsigned slice_size(input int unsigned k);
    return int'(PART_SIZES[k*FW +: FW]);
  endfunction

  function automatic int unsigned slice_base(input int unsigned k);
    int unsigned s = 0;
    for (int unsigned i = 0; i < k; i++) s += slice_size(i);
    return s;
  endfunction

  function automatic int unsigned biggest();
    int unsigned m = 1;
    for (int unsigned i = 0; i < NUM_ROUTES; i++)
      if (slice_size(i) > m) m = slice_size(i);
    return m;
  endfunction

  localparam int unsigned DEPTH = slice_base(NUM_ROUTES);
  localparam int unsigned AW    = rtpq_pkg::width_of(DEPTH);
  localparam int unsigned CW    = $clog2(biggest() + 1);

  logic [NUM_ROUTES-1:0] wr_req_v, rd_req_v, wr_go_v, rd_go_v;
  logic [AW-1:0]         wr_ptr_a [NUM_ROUTES];
  logic [AW-1:0]         rd_ptr_a [NUM_ROUTES];
  logic [AW-1:0]         mem_waddr, mem_raddr;

  for (genvar k = 0; k < NUM_ROUTES; k++) begin : g_part
    assign wr_req_v[k] = wr_en && (wr_route == RW'(k));
    assign rd_req_v[k] = rd_en && (rd_route == RW'(k));

    rtpq_part_ctrl #(
      .AW(AW), .CW(CW), .BASE(slice_base(k)), .SIZE(slice_size(k))
    ) u_ctrl (
      .clk(clk), .rst(rst),
      .wr_req(wr_req_v[k]), .rd_req(rd_req_v[k]),
      .wr_go(wr_go_v[k]),   .rd_go(rd_go_v[k]),
      .wr_ptr(wr_ptr_a[k]), .rd_ptr(rd_ptr_a[k]),
      .full(full[k]),       .empty(empty[k]),
      .wr_err(wr_err[k]),   .rd_err(rd_err[k])
    );
  end

  always_comb begin
    mem_waddr = '0;
    mem_raddr = '0;
    for (int k = 0; k < NUM_ROUTES; k++) begin
      if (wr_req_v[k]) mem_waddr = wr_ptr_a[k];
      if (rd_req_v[k]) mem_raddr = rd_ptr_a[k];
    end
  end

  rtpq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk),
    .we(|wr_go_v), .waddr(mem_waddr), .wdata(wr_data),
    .re(|rd_go_v), .raddr(mem_raddr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= |rd_go_v;
  end

  // R2
  valid_from_pop_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R9
  no_addr_clash_chk: assert property (@(posedge clk) disable iff (rst)
    ((|wr_go_v) && (|rd_go_v)) |-> (mem_waddr != mem_raddr));

  // R3
  one_route_go_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_go_v) && $onehot0(rd_go_v));
endmodule

// File: tb/sim_route_part_fifo.sv
module sim_route_part_fifo;
  localparam int NR = 4;
  localparam int DW = 32;
  localparam int RW = 2;
  localparam int SZ [NR] = '{4, 8, 2, 6};

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [RW-1:0] wr_route = 0, rd_route = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic rd_valid;
  logic [NR-1:0] full, empty, wr_err, rd_err;

  always #4 clk = ~clk;

  route_part_fifo #(.NUM_ROUTES(NR), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_route(wr_route), .wr_data(wr_data),
    .rd_en(rd_en), .rd_route(rd_route), .rd_data(rd_data), .rd_valid(rd_valid),
    .full(full), .empty(empty), .wr_err(wr_err), .rd_err(rd_err));

  logic [DW-1:0] q [NR][$];
  logic [NR-1:0] e_full, e_empty, e_werr, e_rerr;
  logic e_valid;
  logic [DW-1:0] e_data;
  int checks = 0, failures = 0, cycles = 0;
  bit started = 0, done = 0;
  string phase = "R1";

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  // reference model: behavioural queues per route
  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (rst) begin
      for (int k = 0; k < NR; k++) q[k].delete();
      e_werr = 0; e_rerr = 0; e_valid = 0;
    end else begin
      bit wa, ra;
      wa = wr_en && (q[wr_route].size() < SZ[wr_route]);
      ra = rd_en && (q[rd_route].size() > 0);
      e_werr = 0; e_rerr = 0;
      if (wr_en && !wa) e_werr[wr_route] = 1'b1;
      if (rd_en && !ra) e_rerr[rd_route] = 1'b1;
      e_valid = ra;
      if (ra) e_data = q[rd_route].pop_front();
      if (wa) q[wr_route].push_back(wr_data);
    end
    for (int k = 0; k < NR; k++) begin
      e_full[k]  = (q[k].size() == SZ[k]);
      e_empty[k] = (q[k].size() == 0);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(full == e_full, "R4 full", DW'(full), DW'(e_full));
      check(empty == e_empty, "R4 empty", DW'(empty), DW'(e_empty));
      check(wr_err == e_werr, "R5 wr_err", DW'(wr_err), DW'(e_werr));
      check(rd_err == e_rerr, "R6 rd_err", DW'(rd_err), DW'(e_rerr));
      check(rd_valid == e_valid, "R2 rd_valid", DW'(rd_valid), DW'(e_valid));
      if (e_valid) check(rd_data == e_data, "R2 rd_data", rd_data, e_data);
    end
  end

  task automatic op(input bit we, input int wr, input logic [DW-1:0] wd,
                    input bit re, input int rr);
    @(posedge clk); #1;
    wr_en = we; wr_route = RW'(wr); wr_data = wd;
    rd_en = re; rd_route = RW'(rr);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog all act=%0d exp=%0d", cycles, 50000);
      finish_run();
    end
  end

  initial begin
    int seed = 7;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    phase = "R1";
    check(empty == '1 && full == '0, "R1 flags", DW'({full, empty}), DW'(8'h0F));
    check(wr_err == '0 && rd_err == '0 && !rd_valid, "R1 idle", DW'({wr_err, rd_err, rd_valid}), 0);

    // R2: ordered push/pop on route 0
    phase = "R2";
    for (int i = 0; i < 3; i++) op(1, 0, 32'hA000 + i, 0, 0);
    for (int i = 0; i < 3; i++) op(0, 0, 0, 1, 0);

    // R4, R5: fill route 1, overfill, drain
    phase = "R5";
    for (int i = 0; i < 9; i++) op(1, 1, 32'hB100 + i, 0, 0);
    op(1, 1, 32'hDEAD, 0, 0);
    for (int i = 0; i < 8; i++) op(0, 0, 0, 1, 1);

    // R3: interleaved routes
    phase = "R3";
    for (int i = 0; i < 6; i++) op(1, 2 + (i % 2), 32'hC300 + i, i > 2, 3);
    op(0, 0, 0, 1, 2);

    // R6: pop empty routes
    phase = "R6";
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 1, 1);

    // R7: concurrent push and pop, mid-level
    phase = "R7";
    for (int i = 0; i < 10; i++) op(1, 3, 32'hD700 + i, 1, 3);

    // R9: concurrent on full then on empty route 2
    phase = "R9";
    op(1, 2, 32'hE900, 0, 0);
    op(1, 2, 32'hE901, 1, 2);
    op(0, 0, 0, 1, 2);
    op(0, 0, 0, 1, 2);
    op(1, 2, 32'hE902, 1, 2);
    op(0, 0, 0, 1, 2);

    // R8: mixed traffic for wrap-around
    phase = "R8";
    for (int i = 0; i < 400; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      op(seed[3], (seed >> 4) % NR, DW'(seed), seed[9] | seed[10], (seed >> 11) % NR);
    end
    op(0, 0, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule